// File: doc/BRIEF.md
# Wrong-Path Event Detector

This block watches the per-cycle reports of the memory, control-flow and arithmetic units of an out-of-order core. It looks for behaviour that a program on its correct path almost never shows: dereferencing address zero, writing a read-only page, leaving the segment, loading or storing into code, unaligned data or fetch addresses, several TLB misses in flight at once, a burst of mispredictions that resolve while older branches are still open, popping an empty return stack, and dividing by zero. Any such sign means an older unresolved branch is very likely mispredicted, so recovery can start early.

The block raises a one-cycle pulse with a 4-bit kind code, one clock after the report. Reports are checked in the cycle they arrive. Only the misprediction-burst check keeps state: a small counter of mispredictions that resolved with an older branch still open. Choosing which branch to recover and doing the recovery are left to the consumer of the pulse.

Top module: `wpe_detect`

## Requirements
- R1: During and right after reset, `wpe_pulse` is 0 and `wpe_code` is 0.
- R2: A valid memory report whose address is zero raises code 1.
- R3: A valid store to a page marked read-only raises code 2. A load to such a page raises nothing.
- R4: A valid memory report whose address is above `mem_seg_limit` raises code 3.
- R5: A valid memory report to a page marked as code raises code 4.
- R6: A valid memory report whose address is not a multiple of 2^`mem_size` bytes raises code 5.
- R7: `tlb_miss_cnt` of 2 or more raises code 6. A count of 1 raises nothing.
- R8: A misprediction resolved while `br_older_pending` is 1 is counted. The third counted one raises code 7 and restarts the count at zero.
- R9: The misprediction count returns to zero in any cycle with `flush` = 1 or `br_older_pending` = 0. A misprediction resolved in such a cycle is not counted.
- R10: `ras_pop` while `ras_empty` is 1 raises code 8.
- R11: A valid fetch address whose two low bits are not both zero raises code 9.
- R12: A valid divide report with `div_by_zero` = 1 raises code 10.
- R13: The output is registered. For a report in cycle n, `wpe_pulse` and `wpe_code` show the result in cycle n+1. When several kinds fire together, the lowest code is reported. With no event, the pulse is 0 and the code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Pipeline flush; clears the misprediction count |
| mem_valid | input | 1 | Memory report valid |
| mem_addr | input | AW | Effective address of the access |
| mem_is_store | input | 1 | 1 for a store, 0 for a load |
| mem_size | input | SZW | log2 of the access size in bytes |
| mem_page_ro | input | 1 | Page attribute: read-only |
| mem_page_code | input | 1 | Page attribute: code page |
| mem_seg_limit | input | AW | Highest legal address of the segment |
| tlb_miss_cnt | input | TW | TLB misses outstanding this cycle |
| br_resolve | input | 1 | A branch resolves this cycle |
| br_mispredict | input | 1 | The resolving branch was mispredicted |
| br_older_pending | input | 1 | An older branch is still unresolved |
| ras_pop | input | 1 | Return stack is popped |
| ras_empty | input | 1 | Return stack is empty |
| fetch_valid | input | 1 | Fetch address valid |
| fetch_addr | input | AW | Fetch address |
| div_valid | input | 1 | Divide report valid |
| div_by_zero | input | 1 | Divisor of the reported divide is zero |
| wpe_pulse | output | 1 | One-cycle event pulse |
| wpe_code | output | 4 | Event kind, 0 when idle |

## Verification
The assertions assume the control unit reports at most one branch resolution per cycle. They also assume `br_mispredict` is only meaningful while `br_resolve` is high. The stimulus keeps to both rules: it drives a single resolution flag and a mispredict bit per cycle.

The random traffic keeps most accesses aligned, within the segment and on ordinary pages. This way each anomaly shows up alone often enough to be seen, and still collides with others sometimes, which exercises the lowest-code-wins rule. Directed runs cover the misprediction counter at its limit, its clearing by flush and by a missing older branch, and the TLB count at 1 and at 2.

// File: rtl/wpe_pkg.sv
package wpe_pkg;
   localparam int unsigned CODE_W  = 4;
   localparam int unsigned N_KINDS = 10;

   typedef enum logic [CODE_W-1:0] {
      WPE_NONE       = 4'd0,
      WPE_NULL_PTR   = 4'd1,
      WPE_RO_WRITE   = 4'd2,
      WPE_SEG_RANGE  = 4'd3,
      WPE_CODE_DATA  = 4'd4,
      WPE_DATA_ALIGN = 4'd5,
      WPE_TLB_MULTI  = 4'd6,
      WPE_MISP_BURST = 4'd7,
      WPE_RAS_EMPTY  = 4'd8,
      WPE_FETCH_ALGN = 4'd9,
      WPE_DIV_ZERO   = 4'd10
   } wpe_kind_e;

   // bit i of the event vector maps to code i+1
   localparam int unsigned MEM_KINDS  = 6;
   localparam int unsigned CTRL_KINDS = 3;
endpackage

// File: rtl/wpe_mem_check.sv
module wpe_mem_check #(
   parameter int unsigned AW        = 32,
   parameter int unsigned SZW       = 2,
   parameter int unsigned TW        = 4,
   parameter int unsigned TLB_LIMIT = 2
) (
   input  logic           mem_valid,
   input  logic [AW-1:0]  mem_addr,
   input  logic           mem_is_store,
   input  logic [SZW-1:0] mem_size,
   input  logic           mem_page_ro,
   input  logic           mem_page_code,
   input  logic [AW-1:0]  mem_seg_limit,
   input  logic [TW-1:0]  tlb_miss_cnt,
   output logic [wpe_pkg::MEM_KINDS-1:0] mem_ev
);
   localparam int unsigned MAX_SZ = (1 << SZW) - 1;
   localparam int unsigned CHK_B  = (MAX_SZ < AW) ? MAX_SZ : AW;

   generate
      if (TLB_LIMIT < 2) begin : g_bad_tlb
         $error("TLB_LIMIT must be at least 2");
      end
      if (TLB_LIMIT >= (1 << TW)) begin : g_bad_tw
         $error("TW too narrow for TLB_LIMIT");
      end
   endgenerate

   logic misaligned;
   always_comb begin
      misaligned = 1'b0;
      for (int b = 0; b < CHK_B; b++) begin
         if ((b < int'(mem_size)) && mem_addr[b]) misaligned = 1'b1;
      end
   end

   always_comb begin
      mem_ev    = '0;
      mem_ev[0] = mem_valid && (mem_addr == '0);
      mem_ev[1] = mem_valid && mem_is_store && mem_page_ro;
      mem_ev[2] = mem_valid && (mem_addr > mem_seg_limit);
      mem_ev[3] = mem_valid && mem_page_code;
      mem_ev[4] = mem_valid && misaligned;
      mem_ev[5] = (tlb_miss_cnt >= TW'(TLB_LIMIT));
   end
endmodule

// File: rtl/wpe_ctrl_check.sv
module wpe_ctrl_check #(
   parameter int unsigned AW         = 32,
   parameter int unsigned MISP_LIMIT = 3,
   parameter int unsigned FETCH_LSB  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          br_resolve,
   input  logic          br_mispredict,
   input  logic          br_older_pending,
   input  logic          ras_pop,
   input  logic          ras_empty,
   input  logic          fetch_valid,
   input  logic [AW-1:0] fetch_addr,
   output logic [wpe_pkg::CTRL_KINDS-1:0] ctrl_ev
);
   localparam int unsigned CNT_W = $clog2(MISP_LIMIT + 1);

   generate
      if (MISP_LIMIT < 2) begin : g_bad_lim
         $error("MISP_LIMIT must be at least 2");
      end
      if (FETCH_LSB == 0 || FETCH_LSB >= AW) begin : g_bad_lsb
         $error("FETCH_LSB out of range");
      end
   endgenerate

   logic [CNT_W-1:0] misp_cnt;
   logic             counted;
   logic             at_limit;

   assign counted  = br_resolve && br_mispredict && br_older_pending && !flush;
   assign at_limit = (misp_cnt == CNT_W'(MISP_LIMIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)                          misp_cnt <= '0;
      else if (flush || !br_older_pending) misp_cnt <= '0;
      else if (counted) begin
         if (at_limit) misp_cnt <= '0;
         else          misp_cnt <= misp_cnt + 1'b1;
      end
   end

   always_comb begin
      ctrl_ev    = '0;
      ctrl_ev[0] = counted && at_limit;
      ctrl_ev[1] = ras_pop && ras_empty;
      ctrl_ev[2] = fetch_valid && (fetch_addr[FETCH_LSB-1:0] != '0);
   end

   assert_cnt_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flush || !br_older_pending) |=> (misp_cnt == '0));
   assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      misp_cnt < CNT_W'(MISP_LIMIT));
   assert_cnt_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_ev[0] |=> (misp_cnt == '0));
endmodule

// File: rtl/wpe_prio_enc.sv
module wpe_prio_enc #(
   parameter int unsigned N  = 10,
   parameter int unsigned CW = 4
) (
   input  logic [N-1:0]  req,
   output logic [CW-1:0] code,
   output logic          any
);
   generate
      if (N + 1 > (1 << CW)) begin : g_bad_cw
         $error("CW too narrow for N kinds");
      end
   endgenerate

   // per-bit grant chain: a bit wins when no lower bit is set
   logic [N-1:0] below;
   logic [N-1:0] grant;
   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_chain
         if (gi == 0) begin : g_first
            assign below[gi] = 1'b0;
         end else begin : g_rest
            assign below[gi] = below[gi-1] | req[gi-1];
         end
         assign grant[gi] = req[gi] & ~below[gi];
      end
   endgenerate

   always_comb begin
      code = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) code = CW'(i + 1);
      end
   end
   assign any = |req;
endmodule

// File: rtl/wpe_detect.sv
module wpe_detect #(
   parameter int unsigned AW         = 32,
   parameter int unsigned SZW        = 2,
   parameter int unsigned TW         = 4,
   parameter int unsigned TLB_LIMIT  = 2,
   parameter int unsigned MISP_LIMIT = 3,
   parameter int unsigned FETCH_LSB  = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           flush,
   input  logic           mem_valid,
   input  logic [AW-1:0]  mem_addr,
   input  logic           mem_is_store,
   input  logic [SZW-1:0] mem_size,
   input  logic           mem_page_ro,
   input  logic           mem_page_code,
   input  logic [AW-1:0]  mem_seg_limit,
   input  logic [TW-1:0]  tlb_miss_cnt,
   input  logic           br_resolve,
   input  logic           br_mispredict,
   input  logic           br_older_pending,
   input  logic           ras_pop,
   input  logic           ras_empty,
   input  logic           fetch_valid,
   input  logic [AW-1:0]  fetch_addr,
   input  logic           div_valid,
   input  logic           div_by_zero,
   output logic           wpe_pulse,
   output logic [3:0]     wpe_code
);
   import wpe_pkg::*;

   localparam int unsigned NK = MEM_KINDS + CTRL_KINDS + 1;

   generate
      if (NK != N_KINDS) begin : g_bad_nk
         $error("event vector size mismatch");
      end
   endgenerate

   logic [MEM_KINDS-1:0]  mem_ev;
   logic [CTRL_KINDS-1:0] ctrl_ev;
   logic [NK-1:0]         ev_vec;
   logic [CODE_W-1:0]     enc_code;
   logic                  enc_any;

   wpe_mem_check #(.AW(AW), .SZW(SZW), .TW(TW), .TLB_LIMIT(TLB_LIMIT)) u_mem (
      .mem_valid     (mem_valid),
      .mem_addr      (mem_addr),
      .mem_is_store  (mem_is_store),
      .mem_size      (mem_size),
      .mem_page_ro   (mem_page_ro),
      .mem_page_code (mem_page_code),
      .mem_seg_limit (mem_seg_limit),
      .tlb_miss_cnt  (tlb_miss_cnt),
      .mem_ev        (mem_ev)
   );

   wpe_ctrl_check #(.AW(AW), .MISP_LIMIT(MISP_LIMIT), .FETCH_LSB(FETCH_LSB)) u_ctrl (
      .clk              (clk),
      .rst_n            (rst_n),
      .flush            (flush),
      .br_resolve       (br_resolve),
      .br_mispredict    (br_mispredict),
      .br_older_pending (br_older_pending),
      .ras_pop          (ras_pop),
      .ras_empty        (ras_empty),
      .fetch_valid      (fetch_valid),
      .fetch_addr       (fetch_addr),
      .ctrl_ev          (ctrl_ev)
   );

   assign ev_vec = {div_valid && div_by_zero, ctrl_ev, mem_ev};

   wpe_prio_enc #(.N(NK), .CW(CODE_W)) u_enc (
      .req  (ev_vec),
      .code (enc_code),
      .any  (enc_any)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wpe_pulse <= 1'b0;
         wpe_code  <= WPE_NONE;
      end else begin
         wpe_pulse <= enc_any;
         wpe_code  <= enc_code;
      end
   end

   assert_null_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_addr == '0) |=> (wpe_pulse && wpe_code == WPE_NULL_PTR));
   assert_idle_code_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !wpe_pulse |-> (wpe_code == WPE_NONE));
   assert_code_range_R13: assert property (@(posedge clk) disable iff (!rst_n)
      wpe_pulse |-> (wpe_code != WPE_NONE && wpe_code <= WPE_DIV_ZERO));
   assert_tlb_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tlb_miss_cnt >= TW'(TLB_LIMIT)) |=> wpe_pulse);
   assert_div_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (div_valid && div_by_zero) |=> wpe_pulse);
endmodule

// File: tb/wpe_detect_test.sv
module wpe_detect_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;

   logic clk = 1'b0;
   logic rst_n;
   logic flush, mem_valid, mem_is_store, mem_page_ro, mem_page_code;
   logic [AW-1:0] mem_addr, mem_seg_limit, fetch_addr;
   logic [1:0] mem_size;
   logic [3:0] tlb_miss_cnt;
   logic br_resolve, br_mispredict, br_older_pending, ras_pop, ras_empty;
   logic fetch_valid, div_valid, div_by_zero;
   logic wpe_pulse;
   logic [3:0] wpe_code;

   int n_checks = 0;
   int n_fail = 0;
   int m_cnt = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wpe_detect uut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_is_store(mem_is_store),
      .mem_size(mem_size), .mem_page_ro(mem_page_ro), .mem_page_code(mem_page_code),
      .mem_seg_limit(mem_seg_limit), .tlb_miss_cnt(tlb_miss_cnt),
      .br_resolve(br_resolve), .br_mispredict(br_mispredict),
      .br_older_pending(br_older_pending), .ras_pop(ras_pop), .ras_empty(ras_empty),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
      .div_valid(div_valid), .div_by_zero(div_by_zero),
      .wpe_pulse(wpe_pulse), .wpe_code(wpe_code)
   );

   // model: expected code for the current inputs; advances the burst count
   function automatic logic [3:0] model_step();
      logic [3:0] c = 4'd0;
      bit misp = 0;
      logic [AW-1:0] mask = (AW'(1) << mem_size) - 1;
      if (flush || !br_older_pending) m_cnt = 0;
      else if (br_resolve && br_mispredict) begin
         if (m_cnt == 2) begin misp = 1; m_cnt = 0; end
         else m_cnt++;
      end
      if (div_valid && div_by_zero) c = 4'd10;
      if (fetch_valid && fetch_addr[1:0] != 2'b00) c = 4'd9;
      if (ras_pop && ras_empty) c = 4'd8;
      if (misp) c = 4'd7;
      if (tlb_miss_cnt >= 4'd2) c = 4'd6;
      if (mem_valid && (mem_addr & mask) != 0) c = 4'd5;
      if (mem_valid && mem_page_code) c = 4'd4;
      if (mem_valid && mem_addr > mem_seg_limit) c = 4'd3;
      if (mem_valid && mem_is_store && mem_page_ro) c = 4'd2;
      if (mem_valid && mem_addr == 0) c = 4'd1;
      return c;
   endfunction

   task automatic quiet();
      flush = 0; mem_valid = 0; mem_addr = 32'h100; mem_is_store = 0;
      mem_size = 0; mem_page_ro = 0; mem_page_code = 0;
      mem_seg_limit = 32'hF000_0000; tlb_miss_cnt = 0;
      br_resolve = 0; br_mispredict = 0; br_older_pending = 0;
      ras_pop = 0; ras_empty = 0; fetch_valid = 0; fetch_addr = 0;
      div_valid = 0; div_by_zero = 0;
   endtask

   // inputs are set at a falling edge; result is sampled one cycle later
   task automatic step(input string req);
      logic [3:0] exp_c = model_step();
      @(negedge clk);
      n_checks++;
      if (wpe_pulse !== (exp_c != 0) || wpe_code !== exp_c) begin
         n_fail++;
         $display("FAIL %s: pulse=%0b code=%0d expected pulse=%0b code=%0d",
                  req, wpe_pulse, wpe_code, exp_c != 0, exp_c);
      end
   endtask

   task automatic mem_rep(input logic [AW-1:0] a, input logic st, input logic [1:0] sz,
                          input logic ro, input logic cd, input string req);
      quiet();
      mem_valid = 1; mem_addr = a; mem_is_store = st; mem_size = sz;
      mem_page_ro = ro; mem_page_code = cd;
      step(req);
   endtask

   task automatic branch(input logic mis, input logic older, input logic fl, input string req);
      quiet();
      br_resolve = 1; br_mispredict = mis; br_older_pending = older; flush = fl;
      step(req);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog: run did not end");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      quiet();
      rst_n = 0;
      repeat (3) @(negedge clk);
      n_checks++;
      if (wpe_pulse !== 0 || wpe_code !== 0) begin
         n_fail++;
         $display("FAIL R1: pulse=%0b code=%0d expected 0/0", wpe_pulse, wpe_code);
      end
      rst_n = 1;
      quiet(); step("R1");

      mem_rep(32'h0, 0, 2, 0, 0, "R2");
      mem_rep(32'h0, 1, 0, 1, 1, "R2 R13 priority");
      mem_rep(32'h2000, 1, 2, 1, 0, "R3");
      mem_rep(32'h2000, 0, 2, 1, 0, "R3 load ignored");
      mem_rep(32'hF000_0004, 0, 2, 0, 0, "R4");
      mem_rep(32'hF000_0000, 0, 2, 0, 0, "R4 at limit");
      mem_rep(32'h3000, 0, 0, 0, 1, "R5");
      mem_rep(32'h3002, 0, 2, 0, 0, "R6");
      mem_rep(32'h3002, 0, 1, 0, 0, "R6 aligned half");
      mem_rep(32'h3001, 0, 0, 0, 0, "R6 byte never unaligned");
      mem_rep(32'h3006, 0, 3, 0, 1, "R5 R13 priority");

      quiet(); tlb_miss_cnt = 1; step("R7 single");
      quiet(); tlb_miss_cnt = 2; step("R7");
      quiet(); tlb_miss_cnt = 2; div_valid = 1; div_by_zero = 1; step("R7 R13 priority");

      branch(1, 1, 0, "R8 first");
      branch(0, 1, 0, "R8 correct branch");
      branch(1, 1, 0, "R8 second");
      branch(1, 1, 0, "R8 third");
      branch(1, 1, 0, "R8 restart");
      branch(1, 0, 0, "R9 no older");
      branch(1, 1, 0, "R9 a");
      branch(1, 1, 0, "R9 b");
      branch(0, 1, 1, "R9 flush");
      branch(1, 1, 0, "R9 after flush 1");
      branch(1, 1, 0, "R9 after flush 2");
      branch(1, 1, 1, "R9 flush with mispredict");
      branch(1, 1, 0, "R9 c");
      quiet(); step("R9 idle clears");
      branch(1, 1, 0, "R9 d");
      branch(1, 1, 0, "R9 e");
      branch(1, 1, 0, "R8 limit again");

      quiet(); ras_pop = 1; ras_empty = 1; step("R10");
      quiet(); ras_pop = 1; step("R10 nonempty");
      quiet(); fetch_valid = 1; fetch_addr = 32'h1002; step("R11");
      quiet(); fetch_valid = 1; fetch_addr = 32'h1004; step("R11 aligned");
      quiet(); div_valid = 1; div_by_zero = 1; step("R12");
      quiet(); div_by_zero = 1; step("R12 not valid");

      for (int i = 0; i < 3000; i++) begin
         quiet();
         mem_valid = $urandom_range(0, 1);
         mem_size = 2'($urandom_range(0, 3));
         mem_addr = ($urandom() | 32'h10) & ~((AW'(1) << mem_size) - 1);
         if ($urandom_range(0, 15) == 0) mem_addr = mem_addr | 32'h1;
         if ($urandom_range(0, 31) == 0) mem_addr = 0;
         mem_seg_limit = ($urandom_range(0, 7) == 0) ? 32'h4000_0000 : 32'hFFFF_FFF0;
         mem_is_store = $urandom_range(0, 1);
         mem_page_ro = ($urandom_range(0, 7) == 0);
         mem_page_code = ($urandom_range(0, 15) == 0);
         tlb_miss_cnt = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 5)) : 4'd0;
         br_resolve = $urandom_range(0, 1);
         br_mispredict = br_resolve && ($urandom_range(0, 1) == 1);
         br_older_pending = ($urandom_range(0, 7) != 0);
         flush = ($urandom_range(0, 15) == 0);
         ras_pop = $urandom_range(0, 1);
         ras_empty = ($urandom_range(0, 7) == 0);
         fetch_valid = $urandom_range(0, 1);
         fetch_addr = ($urandom_range(0, 7) == 0) ? $urandom() : ($urandom() & ~32'h3);
         div_valid = $urandom_range(0, 1);
         div_by_zero = ($urandom_range(0, 15) == 0);
         step("R13 random");
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule